// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter. It advances on the instruction clock, which is the system clock divided by four. A selectable prescaler of 1, 4 or 16 sits between that clock and the counter. The counter is compared with a programmable period register. When the two are equal, the next increment returns the counter to zero and raises a match pulse for one system clock.

The match pulse goes to two places. It leaves the block on a dedicated port, so that a serial port can use it as its shift clock. It also feeds a 4-bit postscaler. Each time the postscaler rolls over, it sets a sticky interrupt flag. Software reaches the counter, period and control registers over a small synchronous register bus, and clears the flag with a dedicated strobe. A sleep input freezes counting without losing the prescaler's progress.

Top module: `period_timer`

## Requirements
- R1: The counter counts up from 0 to the period value. On the next increment it returns to 0, and `match_pulse` is high for exactly one system clock. With period P and prescale ratio N, consecutive match pulses are 4·N·(P+1) clocks apart.
- R2: Control bits [1:0] select the prescale ratio: 00 gives 1, 01 gives 4, and 10 or 11 give 16.
- R3: Control bits [6:3] hold a value k. The flag is set on every (k+1)-th match pulse and on none of the others.
- R4: Control bit 2 is the run enable. While it is 0, the counter holds its value.
- R5: After reset, the counter reads 0, the period reads 0xFF, the control register reads 0 and the flag is 0.
- R6: A write to the counter or to the control register restarts the prescale and postscale counts. A control write leaves the counter value unchanged.
- R7: While `sleep` is high, the counter and the prescale count hold. Counting resumes when `sleep` falls.
- R8: The flag stays set until `flag_clr` is pulsed. If a new set and a clear fall in the same cycle, the flag ends up set.
- R9: A counter write wins over an increment in the same cycle. The written value reads back on the following cycle.
- R10: Register addresses: 0 is the counter, 1 the period, 2 the control register. Address 3 reads 0. Control bit 7 ignores writes and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Freezes counting while high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| flag_clr | input | 1 | Clears the interrupt flag |
| match_pulse | output | 1 | One-clock period match, usable as a shift clock |
| irq_flag | output | 1 | Sticky postscaler rollover flag |

## Verification
The bench measures the spacing of match pulses for several period and prescale pairs, including both codes that select 16. A wrong prescale decode, or an off-by-one in the counter's wrap, shows up as a wrong gap. It counts match pulses up to the flag, both from a fresh start and after a control rewrite in the middle of a sequence. A postscaler that ignores k+1, or that a control write fails to clear, sets the flag on the wrong pulse. It holds `flag_clr` high across a rollover to catch a clear that beats the set. It also writes the counter at four phase offsets, so that a write which loses to an increment reads back one too high.

// File: rtl/pt_pkg.sv
package pt_pkg;
   typedef enum logic [1:0] {
      REG_COUNT  = 2'd0,
      REG_PERIOD = 2'd1,
      REG_CTRL   = 2'd2,
      REG_SPARE  = 2'd3
   } pt_reg_e;
endpackage

// File: rtl/pt_phase.sv
// Divides the system clock by 2**DIV_W and emits one tick per instruction cycle.
module pt_phase #(
   parameter int DIV_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV_W < 1) begin : g_bad_div
      $error("pt_phase: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= ph_q + 1'b1;
   end

   assign tick = &ph_q;
endmodule

// File: rtl/pt_prescale.sv
// Ratio 2**(STEP*code); codes above MAX_CODE saturate at MAX_CODE.
module pt_prescale #(
   parameter int SEL_W    = 2,
   parameter int STEP     = 2,
   parameter int MAX_CODE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             evt
);
   localparam int CW = STEP * MAX_CODE;

   if (CW < 1 || CW > 16) begin : g_bad_width
      $error("pt_prescale: STEP*MAX_CODE must lie in 1..16");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] term;

   always_comb begin
      int code;
      code = (int'(sel) > MAX_CODE) ? MAX_CODE : int'(sel);
      term = CW'((32'd1 << (STEP * code)) - 32'd1);
   end

   assign evt = step && !clr && (cnt_q == term);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  cnt_q <= '0;
      else if (step)      cnt_q <= (cnt_q == term) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/pt_postscale.sv
// Counts matches; ovf on the (sel+1)-th one.
module pt_postscale #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         match,
   input  logic         clr,
   input  logic [W-1:0] sel,
   output logic         ovf
);
   if (W < 1) begin : g_bad_w
      $error("pt_postscale: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   assign ovf = match && !clr && (cnt_q == sel);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (match)    cnt_q <= (cnt_q == sel) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/period_timer.sv
module period_timer #(
   parameter int CNT_W      = 8,
   parameter int DIV_W      = 2,
   parameter int PRE_SEL_W  = 2,
   parameter int PRE_STEP   = 2,
   parameter int PRE_MAXC   = 2,
   parameter int POST_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   input  logic             flag_clr,
   output logic             match_pulse,
   output logic             irq_flag
);
   import pt_pkg::*;

   localparam int RUN_BIT  = PRE_SEL_W;
   localparam int POST_LSB = PRE_SEL_W + 1;
   localparam int CTL_W    = POST_LSB + POST_W;
   localparam int PAD_W    = CNT_W - CTL_W;

   if (CTL_W >= CNT_W) begin : g_bad_ctl
      $error("period_timer: control fields must leave a spare top bit");
   end

   logic [CNT_W-1:0] cnt_q, per_q;
   logic [CTL_W-1:0] ctl_q;
   logic             flag_q, match_q;

   logic wr_cnt, wr_per, wr_ctl, scaler_clr;
   logic tick, inc, at_per, match_evt, post_ovf;

   assign wr_cnt     = wr_en && (pt_reg_e'(addr) == REG_COUNT);
   assign wr_per     = wr_en && (pt_reg_e'(addr) == REG_PERIOD);
   assign wr_ctl     = wr_en && (pt_reg_e'(addr) == REG_CTRL);
   assign scaler_clr = wr_cnt || wr_ctl;

   pt_phase #(.DIV_W(DIV_W)) u_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   pt_prescale #(
      .SEL_W   (PRE_SEL_W),
      .STEP    (PRE_STEP),
      .MAX_CODE(PRE_MAXC)
   ) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .step (tick && ctl_q[RUN_BIT] && !sleep),
      .clr  (scaler_clr),
      .sel  (ctl_q[PRE_SEL_W-1:0]),
      .evt  (inc)
   );

   assign at_per    = (cnt_q == per_q);
   assign match_evt = inc && at_per && !wr_cnt;

   pt_postscale #(.W(POST_W)) u_post (
      .clk  (clk),
      .rst_n(rst_n),
      .match(match_evt),
      .clr  (scaler_clr),
      .sel  (ctl_q[POST_LSB +: POST_W]),
      .ovf  (post_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         per_q   <= '1;
         ctl_q   <= '0;
         flag_q  <= 1'b0;
         match_q <= 1'b0;
      end else begin
         if (wr_cnt)   cnt_q <= wr_data;
         else if (inc) cnt_q <= at_per ? '0 : cnt_q + 1'b1;
         if (wr_per)   per_q <= wr_data;
         if (wr_ctl)   ctl_q <= wr_data[CTL_W-1:0];
         if (post_ovf)      flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
         match_q <= match_evt;
      end
   end

   always_comb begin
      case (pt_reg_e'(addr))
         REG_COUNT:  rd_data = cnt_q;
         REG_PERIOD: rd_data = per_q;
         REG_CTRL:   rd_data = {{PAD_W{1'b0}}, ctl_q};
         default:    rd_data = '0;
      endcase
   end

   assign match_pulse = match_q;
   assign irq_flag    = flag_q;
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic             flag_clr,
   input logic             match_pulse,
   input logic             irq_flag,
   input logic             run,
   input logic [CNT_W-1:0] cnt
);
   logic cnt_written;
   assign cnt_written = wr_en && (addr == 2'd0);

   assert_match_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |=> !match_pulse);

   assert_match_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> (cnt == '0));

   assert_halt_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run) && !$past(cnt_written)) |-> $stable(cnt));

   assert_sleep_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sleep) && !$past(cnt_written)) |-> $stable(cnt));

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_flag) && !$past(flag_clr)) |-> irq_flag);
endmodule

bind period_timer pt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sleep      (sleep),
   .wr_en      (wr_en),
   .addr       (addr),
   .flag_clr   (flag_clr),
   .match_pulse(match_pulse),
   .irq_flag   (irq_flag),
   .run        (ctl_q[PRE_SEL_W]),
   .cnt        (cnt_q)
);

// File: tb/period_timer_bench.sv
module period_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic       flag_clr = 1'b0;
   logic       match_pulse, irq_flag;

   int checks = 0;
   int errors = 0;

   period_timer u_period_timer (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .flag_clr(flag_clr),
      .match_pulse(match_pulse), .irq_flag(irq_flag)
   );

   always #10 clk = ~clk;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [1:0] a, output int d);
      addr = a;
      #1;
      d = int'(rd_data);
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic wait_match();
      do @(negedge clk); while (!match_pulse);
   endtask

   task automatic gap(output int n);
      wait_match();
      n = 0;
      do begin @(negedge clk); n++; end while (!match_pulse);
   endtask

   task automatic t_reset();
      int v;
      bus_rd(2'd0, v); chk("R5 counter", v, 0);
      bus_rd(2'd1, v); chk("R5 period", v, 255);
      bus_rd(2'd2, v); chk("R5 control", v, 0);
      chk("R5 flag", int'(irq_flag), 0);
      chk("R5 match", int'(match_pulse), 0);
   endtask

   task automatic t_map();
      int v;
      bus_wr(2'd1, 8'h5A);
      bus_rd(2'd1, v); chk("R10 period addr", v, 8'h5A);
      bus_wr(2'd2, 8'h80);
      bus_rd(2'd2, v); chk("R10 control bit7", v, 0);
      bus_rd(2'd3, v); chk("R10 spare addr", v, 0);
      bus_wr(2'd1, 8'hFF);
   endtask

   task automatic t_halt();
      int v;
      bus_wr(2'd2, 8'h00);
      bus_wr(2'd0, 8'h11);
      repeat (60) @(negedge clk);
      bus_rd(2'd0, v); chk("R4 halted counter", v, 8'h11);
   endtask

   task automatic t_period();
      int n, v, mx;
      bus_wr(2'd1, 8'd5);
      bus_wr(2'd2, 8'h04);
      gap(n); chk("R1 gap P=5 N=1", n, 24);
      @(negedge clk); chk("R1 pulse width", int'(match_pulse), 0);
      mx = 0;
      addr = 2'd0;
      repeat (60) begin
         @(negedge clk); #1;
         if (int'(rd_data) > mx) mx = int'(rd_data);
      end
      chk("R1 counter peak", mx, 5);
   endtask

   task automatic t_prescale();
      int n;
      bus_wr(2'd1, 8'd3); bus_wr(2'd2, 8'h05);
      gap(n); chk("R2 ratio 4", n, 64);
      bus_wr(2'd1, 8'd1); bus_wr(2'd2, 8'h06);
      gap(n); chk("R2 ratio 16 code 10", n, 128);
      bus_wr(2'd2, 8'h07);
      gap(n); chk("R2 ratio 16 code 11", n, 128);
      bus_wr(2'd2, 8'h04);
      gap(n); chk("R2 ratio 1", n, 8);
   endtask

   task automatic t_postscale();
      bus_wr(2'd1, 8'd1);
      bus_wr(2'd2, 8'h14);           // k=2, run, ratio 1
      pulse_clr();
      bus_wr(2'd0, 8'd0);
      for (int i = 1; i <= 3; i++) begin
         wait_match();
         chk($sformatf("R3 flag at match %0d", i), int'(irq_flag), (i == 3) ? 1 : 0);
      end
      repeat (30) @(negedge clk);
      chk("R8 flag held", int'(irq_flag), 1);
      pulse_clr();
      chk("R8 flag cleared", int'(irq_flag), 0);
      wait_match();
      chk("R3 flag after wrap", int'(irq_flag), 0);
   endtask

   task automatic t_set_wins();
      bus_wr(2'd2, 8'h04);           // k=0: every match sets
      @(negedge clk); flag_clr = 1'b1;
      wait_match();
      chk("R8 set beats clear", int'(irq_flag), 1);
      @(negedge clk);
      chk("R8 clear after set", int'(irq_flag), 0);
      flag_clr = 1'b0;
   endtask

   task automatic t_ctl_write();
      int v;
      bus_wr(2'd2, 8'h00);
      bus_wr(2'd0, 8'd7);
      bus_wr(2'd2, 8'h19);
      bus_rd(2'd0, v); chk("R6 control write keeps counter", v, 7);
      bus_wr(2'd1, 8'd1);
      bus_wr(2'd2, 8'h1C);           // k=3, run, ratio 1
      pulse_clr();
      bus_wr(2'd0, 8'd0);
      wait_match(); wait_match();
      bus_wr(2'd2, 8'h1C);
      for (int i = 1; i <= 4; i++) begin
         wait_match();
         chk($sformatf("R6 postscale restart match %0d", i), int'(irq_flag), (i == 4) ? 1 : 0);
      end
   endtask

   task automatic t_sleep();
      int a, b;
      bus_wr(2'd1, 8'hFF);
      bus_wr(2'd2, 8'h04);
      bus_wr(2'd0, 8'd0);
      repeat (10) @(negedge clk);
      sleep = 1'b1;
      @(negedge clk);
      bus_rd(2'd0, a);
      repeat (40) @(negedge clk);
      bus_rd(2'd0, b); chk("R7 frozen in sleep", b, a);
      sleep = 1'b0;
      repeat (20) @(negedge clk);
      bus_rd(2'd0, b); chk("R7 resumes on wake", (b > a) ? 1 : 0, 1);
   endtask

   task automatic t_priority();
      int v;
      bus_wr(2'd1, 8'hFF);
      bus_wr(2'd2, 8'h04);
      for (int i = 0; i < 4; i++) begin
         repeat (i) @(negedge clk);
         bus_wr(2'd0, 8'h40);
         bus_rd(2'd0, v); chk($sformatf("R9 write wins offset %0d", i), v, 8'h40);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_halt();
      t_period();
      t_prescale();
      t_postscale();
      t_set_wins();
      t_ctl_write();
      t_sleep();
      t_priority();
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end
endmodule